// File: doc/BRIEF.md
# Weighted Time-Slot Context Scheduler

This block lets several logical cores share one processor datapath by strict time-slicing, with no interrupts. A frame of 16 slots repeats without end. A slot lasts a fixed number of clock cycles, 16 by default. A map fixed at elaboration assigns each slot to one core. A core that owns more slots gets a larger share of the throughput. Because ownership never changes at run time, each core's worst-case wait is known in advance.

For every core the block holds its own register bank and its own flag vector. The slot that is active picks which copy the datapath sees, so moving from one core to the next costs no cycles. The datapath is represented here only by two things: a register write port with two combinational read ports, and a flag update port. Both act on the bank of the active core.

The default map gives slot 0 to core 0, slots 4 and 12 to core 1, and every other slot to core 2. That is a 1:2:13 split.

Top module: `tslot_sched`

## Requirements
- R1: While `rst_ni` is low, and on release, the slot index is 0 and the cycle count is 0. `slot_start_o` is high, `active_core_o` equals the map entry for slot 0, and every core's registers and flags are zero.
- R2: Each slot lasts exactly SLOT_CYCLES clock cycles. At the end of a slot's last cycle, `slot_idx_o` advances by one, and it wraps from 15 to 0.
- R3: `slot_start_o` is high in the first cycle of each slot and low in every other cycle.
- R4: `active_core_o` always equals SLOT_MAP[slot_idx_o]. Entry s of SLOT_MAP is held in bits [2s+1:2s]. The output changes only in a cycle where `slot_start_o` is high.
- R5: When `wr_en_i` is high at a clock edge, `wr_data_i` is stored at `wr_addr_i` in the active core's bank. The banks of the other cores are left unchanged.
- R6: When `flag_we_i` is high at a clock edge, `flag_d_i` replaces the active core's flags. The flags of the other cores are left unchanged.
- R7: `rd_data_a_o` and `rd_data_b_o` return, combinationally, the active core's registers at `rd_addr_a_i` and `rd_addr_b_i`. `flags_o` shows the active core's flags.
- R8: Over each complete frame, core c is active for (number of map entries equal to c) × SLOT_CYCLES cycles. With the default map this is 16, 32 and 208 cycles.
- R9: A read in the same cycle as a write to the same address returns the value held before that write.
- R10: A write issued in the last cycle of a slot lands in the bank of the outgoing core, not the incoming one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_start_o | output | 1 | High in the first cycle of each slot |
| slot_idx_o | output | 4 | Current slot within the frame |
| active_core_o | output | CORE_W | Core that owns the current slot |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_a_i | input | AW | Read port A address |
| rd_data_a_o | output | DATA_W | Read port A data, active core |
| rd_addr_b_i | input | AW | Read port B address |
| rd_data_b_o | output | DATA_W | Read port B data, active core |
| flag_we_i | input | 1 | Flag update enable |
| flag_d_i | input | FLAG_W | New flag value |
| flags_o | output | FLAG_W | Flags of the active core |

## Verification
The bench targets the slot boundary.

- A write made in a slot's last cycle must reach the outgoing core. A design that switched the bank select one cycle early would store it in the incoming core, and the value would show up in the wrong core's readback in the following slots.
- An off-by-one error in the cycle counter would stretch or shorten slots. That shows up as a shifted `slot_start_o` and as wrong per-core cycle totals across a frame.
- A read of an address in the same cycle it is written must return the old value. A design with write-through would fail this.
- A reset in the middle of a frame must clear every bank, not only the active one.

// File: rtl/tslot_pkg.sv
package tslot_pkg;
  localparam int unsigned FRAME_SLOTS = 16;
  localparam int unsigned SLOT_W      = 4;
  localparam int unsigned MAP_ENTRY_W = 2;

  typedef logic [FRAME_SLOTS-1:0][MAP_ENTRY_W-1:0] slot_map_t;

  // 1:2:13 split: slot 0 -> core 0, slots 4 and 12 -> core 1, rest -> core 2
  function automatic slot_map_t weighted_map();
    slot_map_t m;
    for (int s = 0; s < FRAME_SLOTS; s++) m[s] = 2'd2;
    m[0]  = 2'd0;
    m[4]  = 2'd1;
    m[12] = 2'd1;
    return m;
  endfunction
endpackage

// File: rtl/tslot_timer.sv
module tslot_timer #(
  parameter int unsigned SLOT_CYCLES = 16,
  parameter int unsigned CNT_W       = $clog2(SLOT_CYCLES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  output logic [CNT_W-1:0]              cyc_o,
  output logic [tslot_pkg::SLOT_W-1:0]  slot_o,
  output logic                          first_o
);
  localparam logic [CNT_W-1:0] LAST_CYC = CNT_W'(SLOT_CYCLES - 1);

  logic [CNT_W-1:0]             cyc_q;
  logic [tslot_pkg::SLOT_W-1:0] slot_q;
  logic                         last_cyc;

  assign last_cyc = (cyc_q == LAST_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else if (last_cyc) begin
      cyc_q  <= '0;
      slot_q <= slot_q + 1'b1;  // wraps at frame end
    end else begin
      cyc_q  <= cyc_q + 1'b1;
    end
  end

  assign cyc_o   = cyc_q;
  assign slot_o  = slot_q;
  assign first_o = (cyc_q == '0);
endmodule

// File: rtl/tslot_core_sel.sv
module tslot_core_sel #(
  parameter int unsigned          N_CORES  = 3,
  parameter int unsigned          CORE_W   = 2,
  parameter tslot_pkg::slot_map_t SLOT_MAP = tslot_pkg::weighted_map()
) (
  input  logic [tslot_pkg::SLOT_W-1:0] slot_i,
  output logic [CORE_W-1:0]            core_o,
  output logic [N_CORES-1:0]           sel_o
);
  logic [tslot_pkg::MAP_ENTRY_W-1:0] entry;

  assign entry  = SLOT_MAP[slot_i];
  assign core_o = entry[CORE_W-1:0];

  for (genvar c = 0; c < N_CORES; c++) begin : g_sel
    assign sel_o[c] = (core_o == CORE_W'(c));
  end
endmodule

// File: rtl/tslot_ctx_bank.sv
module tslot_ctx_bank #(
  parameter int unsigned N_REGS = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FLAG_W = 4,
  parameter int unsigned AW     = $clog2(N_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              flag_we_i,
  input  logic [FLAG_W-1:0] flag_d_i,
  input  logic [AW-1:0]     rd_addr_a_i,
  input  logic [AW-1:0]     rd_addr_b_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [DATA_W-1:0] regs_q [N_REGS];
  logic [FLAG_W-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_REGS; i++) regs_q[i] <= '0;
    end else if (en_i && wr_en_i) begin
      regs_q[wr_addr_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flags_q <= '0;
    else if (en_i && flag_we_i) flags_q <= flag_d_i;
  end

  assign rd_a_o  = regs_q[rd_addr_a_i];
  assign rd_b_o  = regs_q[rd_addr_b_i];
  assign flags_o = flags_q;
endmodule

// File: rtl/tslot_sched.sv
module tslot_sched #(
  parameter int unsigned          N_CORES     = 3,
  parameter int unsigned          SLOT_CYCLES = 16,
  parameter int unsigned          N_REGS      = 8,
  parameter int unsigned          DATA_W      = 16,
  parameter int unsigned          FLAG_W      = 4,
  parameter tslot_pkg::slot_map_t SLOT_MAP    = tslot_pkg::weighted_map(),
  localparam int unsigned         CORE_W      = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int unsigned         AW          = $clog2(N_REGS),
  localparam int unsigned         CNT_W       = $clog2(SLOT_CYCLES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  output logic                         slot_start_o,
  output logic [tslot_pkg::SLOT_W-1:0] slot_idx_o,
  output logic [CORE_W-1:0]            active_core_o,
  input  logic                         wr_en_i,
  input  logic [AW-1:0]                wr_addr_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic [AW-1:0]                rd_addr_a_i,
  output logic [DATA_W-1:0]            rd_data_a_o,
  input  logic [AW-1:0]                rd_addr_b_i,
  output logic [DATA_W-1:0]            rd_data_b_o,
  input  logic                         flag_we_i,
  input  logic [FLAG_W-1:0]            flag_d_i,
  output logic [FLAG_W-1:0]            flags_o
);
  logic [CNT_W-1:0]             cyc_q;
  logic [tslot_pkg::SLOT_W-1:0] slot_q;
  logic [N_CORES-1:0]           core_sel;
  logic [DATA_W-1:0]            bank_rd_a [N_CORES];
  logic [DATA_W-1:0]            bank_rd_b [N_CORES];
  logic [FLAG_W-1:0]            bank_flags[N_CORES];

  tslot_timer #(
    .SLOT_CYCLES(SLOT_CYCLES),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cyc_o  (cyc_q),
    .slot_o (slot_q),
    .first_o(slot_start_o)
  );

  tslot_core_sel #(
    .N_CORES (N_CORES),
    .CORE_W  (CORE_W),
    .SLOT_MAP(SLOT_MAP)
  ) u_sel (
    .slot_i(slot_q),
    .core_o(active_core_o),
    .sel_o (core_sel)
  );

  for (genvar c = 0; c < N_CORES; c++) begin : g_bank
    tslot_ctx_bank #(
      .N_REGS(N_REGS),
      .DATA_W(DATA_W),
      .FLAG_W(FLAG_W),
      .AW    (AW)
    ) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (core_sel[c]),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .flag_we_i  (flag_we_i),
      .flag_d_i   (flag_d_i),
      .rd_addr_a_i(rd_addr_a_i),
      .rd_addr_b_i(rd_addr_b_i),
      .rd_a_o     (bank_rd_a[c]),
      .rd_b_o     (bank_rd_b[c]),
      .flags_o    (bank_flags[c])
    );
  end

  // one-hot AND-OR mux keeps read depth at one level per core
  always_comb begin
    rd_data_a_o = '0;
    rd_data_b_o = '0;
    flags_o     = '0;
    for (int c = 0; c < N_CORES; c++) begin
      rd_data_a_o |= bank_rd_a[c]  & {DATA_W{core_sel[c]}};
      rd_data_b_o |= bank_rd_b[c]  & {DATA_W{core_sel[c]}};
      flags_o     |= bank_flags[c] & {FLAG_W{core_sel[c]}};
    end
  end

  assign slot_idx_o = slot_q;
endmodule

// File: rtl/tslot_sched_chk.sv
module tslot_sched_chk #(
  parameter int unsigned SLOT_CYCLES = 16,
  parameter int unsigned CORE_W      = 2,
  parameter int unsigned AW          = 3,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned FLAG_W      = 4,
  parameter int unsigned CNT_W       = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         slot_start_o,
  input logic [tslot_pkg::SLOT_W-1:0] slot_idx_o,
  input logic [CORE_W-1:0]            active_core_o,
  input logic                         wr_en_i,
  input logic [AW-1:0]                wr_addr_i,
  input logic [DATA_W-1:0]            wr_data_i,
  input logic [AW-1:0]                rd_addr_a_i,
  input logic [DATA_W-1:0]            rd_data_a_o,
  input logic                         flag_we_i,
  input logic [FLAG_W-1:0]            flag_d_i,
  input logic [FLAG_W-1:0]            flags_o,
  input logic [CNT_W-1:0]             cyc_q
);
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  p_slot_adv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && slot_start_o |-> slot_idx_o == $past(slot_idx_o) + 1'b1);

  p_slot_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !slot_start_o |-> $stable(slot_idx_o));

  p_start_after_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && slot_start_o |-> $past(cyc_q) == CNT_W'(SLOT_CYCLES - 1));

  p_core_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !slot_start_o |-> $stable(active_core_o));

  p_rd_after_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(wr_en_i) && $stable(active_core_o) && rd_addr_a_i == $past(wr_addr_i)
      |-> rd_data_a_o == $past(wr_data_i));

  p_flag_upd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(flag_we_i) && $stable(active_core_o) |-> flags_o == $past(flag_d_i));
endmodule

bind tslot_sched tslot_sched_chk #(
  .SLOT_CYCLES(SLOT_CYCLES),
  .CORE_W     (CORE_W),
  .AW         (AW),
  .DATA_W     (DATA_W),
  .FLAG_W     (FLAG_W),
  .CNT_W      (CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slot_start_o (slot_start_o),
  .slot_idx_o   (slot_idx_o),
  .active_core_o(active_core_o),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .rd_addr_a_i  (rd_addr_a_i),
  .rd_data_a_o  (rd_data_a_o),
  .flag_we_i    (flag_we_i),
  .flag_d_i     (flag_d_i),
  .flags_o      (flags_o),
  .cyc_q        (cyc_q)
);

// File: tb/tslot_sched_tb.sv
`timescale 1ns/1ps
module tslot_sched_tb;
  localparam int NC = 3;
  localparam int SC = 16;
  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        slot_start_o;
  logic [3:0]  slot_idx_o;
  logic [1:0]  active_core_o;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [2:0]  rd_addr_a_i = '0;
  logic [15:0] rd_data_a_o;
  logic [2:0]  rd_addr_b_i = '0;
  logic [15:0] rd_data_b_o;
  logic        flag_we_i = 1'b0;
  logic [3:0]  flag_d_i = '0;
  logic [3:0]  flags_o;

  always #2 clk = ~clk;

  tslot_sched u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .slot_start_o(slot_start_o), .slot_idx_o(slot_idx_o), .active_core_o(active_core_o),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_a_i(rd_addr_a_i), .rd_data_a_o(rd_data_a_o),
    .rd_addr_b_i(rd_addr_b_i), .rd_data_b_o(rd_data_b_o),
    .flag_we_i(flag_we_i), .flag_d_i(flag_d_i), .flags_o(flags_o)
  );

  // expected slot ownership, written independently
  int exp_map [16] = '{0, 2, 2, 2, 1, 2, 2, 2, 2, 2, 2, 2, 1, 2, 2, 2};
  int exp_share [NC] = '{16, 32, 208};

  logic [15:0] m_regs [NC][NR];
  logic [3:0]  m_flags [NC];
  int m_cyc, m_slot;
  int share_cnt [NC];
  bit frame_valid;
  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      m_flags[c] = '0;
      share_cnt[c] = 0;
      for (int r = 0; r < NR; r++) m_regs[c][r] = '0;
    end
    m_cyc = 0;
    m_slot = 0;
    frame_valid = 0;
  endtask

  task automatic model_tick();
    int core;
    core = exp_map[m_slot];
    if (wr_en_i)   m_regs[core][wr_addr_i] = wr_data_i;
    if (flag_we_i) m_flags[core] = flag_d_i;
    m_cyc++;
    if (m_cyc == SC) begin
      m_cyc = 0;
      m_slot = (m_slot + 1) % 16;
    end
  endtask

  task automatic check_outputs(input string rd_tag);
    int core;
    core = exp_map[m_slot];
    chk("R2 slot index", 32'(slot_idx_o), 32'(m_slot));
    chk("R3 slot start", 32'(slot_start_o), 32'(m_cyc == 0));
    chk("R4 active core", 32'(active_core_o), 32'(core));
    chk({rd_tag, " read A"}, 32'(rd_data_a_o), 32'(m_regs[core][rd_addr_a_i]));
    chk("R7 read B", 32'(rd_data_b_o), 32'(m_regs[core][rd_addr_b_i]));
    chk("R6 flags", 32'(flags_o), 32'(m_flags[core]));
    // R8 per-frame share
    if (m_slot == 0 && m_cyc == 0) begin
      if (frame_valid)
        for (int c = 0; c < NC; c++) chk("R8 frame share", 32'(share_cnt[c]), 32'(exp_share[c]));
      for (int c = 0; c < NC; c++) share_cnt[c] = 0;
      frame_valid = 1;
    end
    if (active_core_o < NC) share_cnt[active_core_o]++;
  endtask

  task automatic step(input logic we, input logic [2:0] wa, input logic [15:0] wd,
                      input logic fwe, input logic [3:0] fd,
                      input logic [2:0] ra, input logic [2:0] rb, input string tag);
    int core;
    @(negedge clk);
    check_outputs(tag);
    wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    flag_we_i = fwe; flag_d_i = fd;
    rd_addr_a_i = ra; rd_addr_b_i = rb;
    #0.5;
    core = exp_map[m_slot];
    if (we && ra == wa)  // R9: same-cycle read sees pre-write value
      chk("R9 read during write", 32'(rd_data_a_o), 32'(m_regs[core][ra]));
    model_tick();
  endtask

  task automatic do_reset();
    @(negedge clk);
    wr_en_i = 1'b0; flag_we_i = 1'b0;
    rst_ni = 1'b0;
    model_reset();
    #0.5;
    chk("R1 slot index", 32'(slot_idx_o), 0);
    chk("R1 slot start", 32'(slot_start_o), 1);
    chk("R1 active core", 32'(active_core_o), 32'(exp_map[0]));
    chk("R1 flags", 32'(flags_o), 0);
    chk("R1 read A", 32'(rd_data_a_o), 0);
    chk("R1 read B", 32'(rd_data_b_o), 0);
    #0.5;
    rst_ni = 1'b1;
    model_tick();
  endtask

  task automatic rand_step(input string tag);
    step($urandom_range(1, 0) == 1, 3'($urandom), 16'($urandom),
         $urandom_range(3, 0) == 0, 4'($urandom),
         3'($urandom), 3'($urandom), tag);
  endtask

  initial begin
    model_reset();
    repeat (2) @(posedge clk);
    do_reset();
    for (int i = 0; i < 2600; i++) rand_step("R5");

    // R10: write in the last cycle of slot 3 (core 2) before slot 4 (core 1)
    while (!(m_slot == 3 && m_cyc == SC - 1)) step(1'b0, '0, '0, 1'b0, '0, 3'd5, 3'd0, "R7");
    step(1'b1, 3'd5, 16'hA5A5, 1'b0, '0, 3'd5, 3'd0, "R10");
    while (m_slot == 4) step(1'b0, '0, '0, 1'b0, '0, 3'd5, 3'd0, "R10");
    @(negedge clk);
    chk("R10 outgoing core holds write", 32'(rd_data_a_o), 32'h0000A5A5);
    check_outputs("R10");
    model_tick();

    // mid-frame reset, then verify all banks cleared as each core comes up
    for (int i = 0; i < 100; i++) rand_step("R5");
    do_reset();
    for (int i = 0; i < 300; i++)
      step(1'b0, '0, '0, 1'b0, '0, 3'($urandom), 3'($urandom), "R1");
    for (int i = 0; i < 600; i++) rand_step("R5");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule